// File: doc/BRIEF.md
# Folded Cube-Connected Cycles Neighbour Label Generator

This block serves one node of an n-dimensional folded cube-connected cycles network. A node is named by a label made of two parts. The first is an n-bit cube address. The second is a ring position that runs from 0 to n. From one such label the block works out the labels of the node's three neighbours:

- the next node along its ring;
- the previous node along its ring;
- the node reached over its cube link.

At ring positions below n, the cube link inverts exactly one address bit: the bit whose index equals the position. At position n the link is the folded one, and it inverts the whole address. Every valid node therefore has exactly three neighbours.

The same request also carries a query label, for example the destination of a hop. The block reports which of the three outgoing ports leads to that label, or reports that none does. A routing stage upstream sends one label plus one query per transfer. It then reads all results together, one cycle later, from a registered output stage that uses a valid/ready handshake. The network dimension is a parameter, and the address and position widths are derived from it.

Top module: `fccc_nbr_gen`

## Requirements
- R1: For a valid position p, the ring-next label has the same cube address and position p+1, except that position n gives position 0.
- R2: For a valid position p, the ring-previous label has the same cube address and position p-1, except that position 0 gives position n.
- R3: For a position p below n, the cube-link label keeps position p and has an address that differs from the input address in bit p alone.
- R4: For position n, the cube-link label keeps position n and has the bitwise complement of the input address.
- R5: The port code is 2'b00 when the query equals the ring-next label, 2'b01 when it equals the ring-previous label, 2'b10 when it equals the cube-link label, and 2'b11 otherwise. When several labels match, the lowest code wins.
- R6: A request whose position is greater than n raises the error output. It then returns all-zero neighbour addresses and positions, and port code 2'b11.
- R7: A request accepted on a clock edge (in_valid and in_ready both high) has its results on the outputs, with out_valid high, after that edge. out_valid falls after an edge where it was high, out_ready was high and no new request was accepted.
- R8: While out_valid is high and out_ready is low, in_ready is low and every output holds its value. Any request offered during that time is not taken until the stall ends.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_addr | input | DIM | Cube address of the node |
| in_pos | input | PW | Ring position of the node |
| in_qaddr | input | DIM | Cube address of the query label |
| in_qpos | input | PW | Ring position of the query label |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Request position was out of range |
| out_succ_addr | output | DIM | Ring-next address |
| out_succ_pos | output | PW | Ring-next position |
| out_pred_addr | output | DIM | Ring-previous address |
| out_pred_pos | output | PW | Ring-previous position |
| out_cross_addr | output | DIM | Cube-link address |
| out_cross_pos | output | PW | Cube-link position |
| out_port | output | 2 | Port code for the query label |

## Verification
Two functions can fall in the same cycle: a new request arriving and a consumer stall holding an earlier result. The bench provokes this by taking one request with out_ready low, then offering a different request for several cycles. In those cycles it judges in_ready and the held outputs against the first request's expected labels. It then raises out_ready and checks that the second request appears one cycle later. All other transfers stream back to back, and neighbour labels are wrapped and complemented arithmetically in the bench for every address, every position (including the out-of-range ones) and four query kinds.

// File: rtl/fccc_pkg.sv
package fccc_pkg;

    typedef enum logic [1:0] {
        PORT_SUCC  = 2'b00,
        PORT_PRED  = 2'b01,
        PORT_CROSS = 2'b10,
        PORT_NONE  = 2'b11
    } port_code_e;

endpackage

// File: rtl/fccc_ring_step.sv
module fccc_ring_step #(
    parameter int DIM = 4,
    localparam int PW = $clog2(DIM + 1)
) (
    input  logic [PW-1:0] pos,
    output logic [PW-1:0] succ_pos,
    output logic [PW-1:0] pred_pos,
    output logic          pos_bad
);
    localparam logic [PW-1:0] LAST_POS = PW'(DIM);

    always_comb begin
        pos_bad  = (pos > LAST_POS);
        succ_pos = (pos == LAST_POS) ? '0 : pos + PW'(1);
        pred_pos = (pos == '0) ? LAST_POS : pos - PW'(1);
    end

endmodule

// File: rtl/fccc_cross_link.sv
module fccc_cross_link #(
    parameter int DIM = 4,
    localparam int PW = $clog2(DIM + 1)
) (
    input  logic [DIM-1:0] addr,
    input  logic [PW-1:0]  pos,
    output logic [DIM-1:0] cross_addr
);
    localparam logic [PW-1:0] LAST_POS = PW'(DIM);

    logic folded;
    assign folded = (pos == LAST_POS);

    for (genvar b = 0; b < DIM; b++) begin : g_bit
        logic flip;
        assign flip          = folded || (pos == PW'(b));
        assign cross_addr[b] = addr[b] ^ flip;
    end

endmodule

// File: rtl/fccc_port_decode.sv
module fccc_port_decode
    import fccc_pkg::*;
#(
    parameter int DIM = 4,
    localparam int PW = $clog2(DIM + 1)
) (
    input  logic [DIM-1:0] q_addr,
    input  logic [PW-1:0]  q_pos,
    input  logic [DIM-1:0] self_addr,
    input  logic [PW-1:0]  succ_pos,
    input  logic [PW-1:0]  pred_pos,
    input  logic [DIM-1:0] cross_addr,
    input  logic [PW-1:0]  cross_pos,
    input  logic           bad,
    output port_code_e     code
);
    logic hit_succ, hit_pred, hit_cross;

    always_comb begin
        hit_succ  = (q_addr == self_addr)  && (q_pos == succ_pos);
        hit_pred  = (q_addr == self_addr)  && (q_pos == pred_pos);
        hit_cross = (q_addr == cross_addr) && (q_pos == cross_pos);
        if (bad)            code = PORT_NONE;
        else if (hit_succ)  code = PORT_SUCC;
        else if (hit_pred)  code = PORT_PRED;
        else if (hit_cross) code = PORT_CROSS;
        else                code = PORT_NONE;
    end

endmodule

// File: rtl/fccc_nbr_gen.sv
module fccc_nbr_gen
    import fccc_pkg::*;
#(
    parameter int DIM = 4,
    localparam int PW = $clog2(DIM + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [DIM-1:0] in_addr,
    input  logic [PW-1:0]  in_pos,
    input  logic [DIM-1:0] in_qaddr,
    input  logic [PW-1:0]  in_qpos,
    output logic           out_valid,
    input  logic           out_ready,
    output logic           out_err,
    output logic [DIM-1:0] out_succ_addr,
    output logic [PW-1:0]  out_succ_pos,
    output logic [DIM-1:0] out_pred_addr,
    output logic [PW-1:0]  out_pred_pos,
    output logic [DIM-1:0] out_cross_addr,
    output logic [PW-1:0]  out_cross_pos,
    output logic [1:0]     out_port
);
    localparam logic [PW-1:0] LAST_POS = PW'(DIM);

    typedef struct packed {
        logic           valid;
        logic           err;
        logic [DIM-1:0] succ_addr;
        logic [PW-1:0]  succ_pos;
        logic [DIM-1:0] pred_addr;
        logic [PW-1:0]  pred_pos;
        logic [DIM-1:0] cross_addr;
        logic [PW-1:0]  cross_pos;
        port_code_e     port;
    } stage_t;

    stage_t st_d, st_q;

    logic [PW-1:0]  ring_succ_pos, ring_pred_pos;
    logic           ring_bad;
    logic [DIM-1:0] link_addr;
    port_code_e     dec_code;
    logic           take;

    fccc_ring_step #(.DIM(DIM)) u_ring (
        .pos      (in_pos),
        .succ_pos (ring_succ_pos),
        .pred_pos (ring_pred_pos),
        .pos_bad  (ring_bad)
    );

    fccc_cross_link #(.DIM(DIM)) u_cross (
        .addr       (in_addr),
        .pos        (in_pos),
        .cross_addr (link_addr)
    );

    fccc_port_decode #(.DIM(DIM)) u_decode (
        .q_addr     (in_qaddr),
        .q_pos      (in_qpos),
        .self_addr  (in_addr),
        .succ_pos   (ring_succ_pos),
        .pred_pos   (ring_pred_pos),
        .cross_addr (link_addr),
        .cross_pos  (in_pos),
        .bad        (ring_bad),
        .code       (dec_code)
    );

    assign in_ready = !st_q.valid || out_ready;
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.err   = ring_bad;
            st_d.port  = dec_code;
            if (ring_bad) begin
                st_d.succ_addr  = '0;
                st_d.succ_pos   = '0;
                st_d.pred_addr  = '0;
                st_d.pred_pos   = '0;
                st_d.cross_addr = '0;
                st_d.cross_pos  = '0;
            end else begin
                st_d.succ_addr  = in_addr;
                st_d.succ_pos   = ring_succ_pos;
                st_d.pred_addr  = in_addr;
                st_d.pred_pos   = ring_pred_pos;
                st_d.cross_addr = link_addr;
                st_d.cross_pos  = in_pos;
            end
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.port <= PORT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.valid;
    assign out_err        = st_q.err;
    assign out_succ_addr  = st_q.succ_addr;
    assign out_succ_pos   = st_q.succ_pos;
    assign out_pred_addr  = st_q.pred_addr;
    assign out_pred_pos   = st_q.pred_pos;
    assign out_cross_addr = st_q.cross_addr;
    assign out_cross_pos  = st_q.cross_pos;
    assign out_port       = st_q.port;

    // R1/R2: both ring neighbours share the node's cube address
    a_r1_ring_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_succ_addr == out_pred_addr));

    // R3: non-folded cube link inverts exactly one bit
    a_r3_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_cross_pos != LAST_POS)
            |-> ($countones(out_cross_addr ^ out_succ_addr) == 1));

    // R4: folded cube link inverts every bit
    a_r4_folded: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && out_cross_pos == LAST_POS)
            |-> (out_cross_addr == ~out_succ_addr));

    // R6: an out-of-range request reports no port
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_port == 2'b11 && out_succ_addr == '0));

    // R7: an accepted request is presented on the next cycle
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R8: a stalled result holds still
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(st_q)));

endmodule

// File: tb/tb_fccc_nbr_gen.sv
module tb_fccc_nbr_gen;
    localparam int DIM = 4;
    localparam int PW  = $clog2(DIM + 1);
    localparam int VW  = 3 * DIM + 3 * PW + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [DIM-1:0] in_addr = '0;
    logic [PW-1:0]  in_pos = '0;
    logic [DIM-1:0] in_qaddr = '0;
    logic [PW-1:0]  in_qpos = '0;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic           out_err;
    logic [DIM-1:0] out_succ_addr, out_pred_addr, out_cross_addr;
    logic [PW-1:0]  out_succ_pos, out_pred_pos, out_cross_pos;
    logic [1:0]     out_port;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fccc_nbr_gen #(.DIM(DIM)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_pos(in_pos),
        .in_qaddr(in_qaddr), .in_qpos(in_qpos),
        .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
        .out_succ_addr(out_succ_addr), .out_succ_pos(out_succ_pos),
        .out_pred_addr(out_pred_addr), .out_pred_pos(out_pred_pos),
        .out_cross_addr(out_cross_addr), .out_cross_pos(out_cross_pos),
        .out_port(out_port)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            report();
        end
    end

    function automatic logic [VW-1:0] expect_vec(input logic [DIM-1:0] a, input logic [PW-1:0] p);
        logic [DIM-1:0] ca;
        logic [PW-1:0]  sp, pp;
        if (p > PW'(DIM)) return '0 | VW'(1);
        sp = (p == PW'(DIM)) ? '0 : p + PW'(1);
        pp = (p == '0) ? PW'(DIM) : p - PW'(1);
        ca = (p == PW'(DIM)) ? ~a : (a ^ (DIM'(1) << p));
        return {a, sp, a, pp, ca, p, 1'b0};
    endfunction

    function automatic logic [VW-1:0] got_vec();
        return {out_succ_addr, out_succ_pos, out_pred_addr, out_pred_pos,
                out_cross_addr, out_cross_pos, out_err};
    endfunction

    function automatic logic [1:0] expect_port(input logic [DIM-1:0] a, input logic [PW-1:0] p,
                                               input logic [DIM-1:0] qa, input logic [PW-1:0] qp);
        logic [VW-1:0] e;
        if (p > PW'(DIM)) return 2'b11;
        e = expect_vec(a, p);
        if (qa == a && qp == e[3*PW+2*DIM:2*PW+2*DIM+1]) return 2'b00;
        if (qa == a && qp == e[2*PW+DIM:PW+DIM+1]) return 2'b01;
        if (qa == e[PW+DIM:PW+1] && qp == p) return 2'b10;
        return 2'b11;
    endfunction

    // Offer one request at a negedge, check its result one cycle later
    task automatic transfer(input logic [DIM-1:0] a, input logic [PW-1:0] p,
                            input logic [DIM-1:0] qa, input logic [PW-1:0] qp);
        logic [VW-1:0] ev;
        in_valid = 1'b1; in_addr = a; in_pos = p; in_qaddr = qa; in_qpos = qp;
        @(posedge clk);
        @(negedge clk);
        ev = expect_vec(a, p);
        chk(out_valid, "R7 out_valid after accept", 64'(out_valid), 64'd1);
        if (p > PW'(DIM))
            chk(got_vec() == ev, "R6 error zeroes labels", 64'(got_vec()), 64'(ev));
        else if (p == PW'(DIM))
            chk(got_vec() == ev, "R1 R2 R4 labels at last position", 64'(got_vec()), 64'(ev));
        else
            chk(got_vec() == ev, "R1 R2 R3 labels", 64'(got_vec()), 64'(ev));
        chk(out_port == expect_port(a, p, qa, qp), "R5 port code",
            64'(out_port), 64'(expect_port(a, p, qa, qp)));
    endtask

    initial begin
        logic [VW-1:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_valid == 1'b0, "R9 out_valid low in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 idle after reset",
            64'({out_valid, in_ready}), 64'b01);

        // Sweep every address, every position encoding, four query kinds
        for (int a = 0; a < (1 << DIM); a++) begin
            for (int p = 0; p < (1 << PW); p++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [VW-1:0] e;
                    logic [DIM-1:0] qa;
                    logic [PW-1:0]  qp;
                    e = expect_vec(DIM'(a), PW'(p));
                    qa = DIM'(a);
                    qp = PW'(p);
                    if (p <= DIM) begin
                        case (k)
                            0: qp = e[3*PW+2*DIM:2*PW+2*DIM+1];
                            1: qp = e[2*PW+DIM:PW+DIM+1];
                            2: qa = e[PW+DIM:PW+1];
                            default: ;
                        endcase
                    end
                    transfer(DIM'(a), PW'(p), qa, qp);
                end
            end
        end

        // R7: with no new request, the result drains
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 drains when idle", 64'(out_valid), 64'd0);

        // R8: stall while a different request is offered
        out_ready = 1'b0;
        transfer(4'b1010, 3'd4, 4'b0101, 3'd4);
        held = expect_vec(4'b1010, 3'd4);
        in_valid = 1'b1; in_addr = 4'b0011; in_pos = 3'd1; in_qaddr = 4'b0011; in_qpos = 3'd0;
        for (int s = 0; s < 3; s++) begin
            @(posedge clk);
            @(negedge clk);
            chk(in_ready == 1'b0, "R8 in_ready low in stall", 64'(in_ready), 64'd0);
            chk(out_valid && got_vec() == held && out_port == 2'b10,
                "R8 outputs held in stall", 64'(got_vec()), 64'(held));
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(got_vec() == expect_vec(4'b0011, 3'd1) && out_port == 2'b01,
            "R8 R7 pending request taken after stall",
            64'(got_vec()), 64'(expect_vec(4'b0011, 3'd1)));
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 drained", 64'(out_valid), 64'd0);

        done = 1;
        report();
    end

endmodule